// File: doc/BRIEF.md
# E1 Transmit Slot Mapper with Periodic Sync Marker

This block produces the transmit side of a 2.048 Mb/s E1 frame for a link that carries eight voice channels and one signalling channel. It emits one bit per clock, most significant bit first. A frame is 32 slots of 8 bits. For each slot it picks the byte to send:

- the alignment or non-alignment word in slot 0;
- a voice byte in slots 1 to 8;
- the signalling byte in slot 16;
- a sync marker byte in slot 17;
- a fixed filler byte in every other slot.

A frame counter spans 2560 frames, which is 320 ms at 125 µs per frame. Slot 17 carries an all-ones marker only in frame 0 of that span, so the far end can recover a slow timing reference from the payload itself.

The voice source is addressed by slot. The block shows on `voice_ch` the channel whose slot comes next. It takes the byte from `voice_byte` on the clock edge that begins that slot, so the source may change the byte during the slot without harm. A frame strobe realigns the bit and slot position to the start of a new frame.

Top module: `e1_slot_mapper`

## Requirements
- R1: Each clock shifts out one bit, most significant bit first. A slot lasts 8 clocks and a frame has 32 slots. `tx_slot` gives the index of the slot whose bit is on `tx_bit`.
- R2: Slot 0 carries 8'h9B in frames with an even frame number and 8'h40 in frames with an odd frame number.
- R3: Slot k, for k from 1 to 8, carries voice channel k-1. `voice_ch` gives the channel of the slot after the current one. The byte is taken from `voice_byte` on the edge that starts the slot. A change to `voice_byte` after that edge has no effect on that slot, and it appears at the next occurrence of that slot.
- R4: Slots 9 to 15 and 18 to 31 carry the filler byte 8'hD5.
- R5: Slot 16 carries `sig_byte` as taken on the edge that starts slot 16.
- R6: The frame number counts from 0 to 2559 and then wraps to 0. Slot 17 carries 8'hFF in frame 0 and 8'h00 in every other frame.
- R7: When `frame_strobe` is high on a clock edge, the next cycle shows bit 0 of slot 0, and the frame number advances by one modulo 2560. This holds whatever the position was before the strobe.
- R8: During reset and just after it, the output is at bit 0 of slot 0 of frame 0, so the first byte sent is 8'h9B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_strobe | input | 1 | Forces a new frame to start on the next cycle |
| voice_byte | input | 8 | Byte for the channel shown on `voice_ch` |
| voice_ch | output | 3 | Voice channel of the slot after the current one |
| sig_byte | input | 8 | Signalling byte for slot 16 |
| tx_bit | output | 1 | Serial line bit |
| tx_slot | output | 5 | Index of the slot now being sent |

## Verification
The properties assume that `frame_strobe`, `voice_byte` and `sig_byte` are synchronous to `clk` and settled at each rising edge. The signalling and voice byte checks depend on this, because they compare the loaded word with the input value seen at the loading edge. The strobe may stay high for many cycles; each such cycle counts as a full frame advance. The bench changes every input only on the falling edge. It holds the strobe high for long runs to reach the frame-number wrap within a short run time, and it changes a voice byte in the middle of its own slot to show that the slot keeps the byte it was given.

// File: rtl/e1sm_pkg.sv
package e1sm_pkg;

    // Frame geometry
    localparam int unsigned DEF_SLOTS       = 32;
    localparam int unsigned DEF_BITS        = 8;
    localparam int unsigned DEF_PERIOD      = 2560;

    // Slot plan
    localparam int unsigned DEF_VOICE_FIRST = 1;
    localparam int unsigned DEF_VOICE_CNT   = 8;
    localparam int unsigned DEF_SIG_SLOT    = 16;
    localparam int unsigned DEF_SYNC_SLOT   = 17;

    // Fixed words
    localparam logic [7:0] DEF_ALIGN_WORD    = 8'h9B;
    localparam logic [7:0] DEF_NONALIGN_WORD = 8'h40;
    localparam logic [7:0] DEF_IDLE_FILL     = 8'hD5;
    localparam logic [7:0] DEF_PULSE_ON      = 8'hFF;
    localparam logic [7:0] DEF_PULSE_OFF     = 8'h00;

    typedef enum logic [2:0] {
        SK_ALIGN,
        SK_VOICE,
        SK_SIG,
        SK_SYNC,
        SK_IDLE
    } slot_kind_e;

endpackage

// File: rtl/e1sm_timebase.sv
module e1sm_timebase #(
    parameter int unsigned SLOTS       = 32,
    parameter int unsigned BITS        = 8,
    parameter int unsigned PERIOD      = 2560,
    parameter int unsigned VOICE_FIRST = 1,
    parameter int unsigned SLOT_W      = 5,
    parameter int unsigned FRM_W       = 12,
    parameter int unsigned CH_W        = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_strobe,
    output logic [SLOT_W-1:0] slot_q,
    output logic [FRM_W-1:0]  frame_q,
    output logic              load,
    output logic [SLOT_W-1:0] nxt_slot,
    output logic [FRM_W-1:0]  nxt_frame,
    output logic [CH_W-1:0]   req_ch
);

    localparam int unsigned BIT_W = (BITS > 1) ? $clog2(BITS) : 1;
    localparam logic [BIT_W-1:0]  LAST_BIT   = BIT_W'(BITS - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(SLOTS - 1);
    localparam logic [FRM_W-1:0]  LAST_FRAME = FRM_W'(PERIOD - 1);
    localparam logic [SLOT_W-1:0] VF_S       = SLOT_W'(VOICE_FIRST);

    typedef struct packed {
        logic [BIT_W-1:0]  bitc;
        logic [SLOT_W-1:0] slot;
        logic [FRM_W-1:0]  frame;
    } pos_t;

    pos_t st_d, st_q;
    logic [SLOT_W-1:0] slot_seq;
    logic [FRM_W-1:0]  frame_inc;
    logic              load_d;

    always_comb begin
        st_d      = st_q;
        load_d    = 1'b0;
        slot_seq  = (st_q.slot == LAST_SLOT) ? '0 : st_q.slot + 1'b1;
        frame_inc = (st_q.frame == LAST_FRAME) ? '0 : st_q.frame + 1'b1;
        if (frame_strobe) begin
            st_d.bitc  = '0;
            st_d.slot  = '0;
            st_d.frame = frame_inc;
            load_d     = 1'b1;
        end else if (st_q.bitc == LAST_BIT) begin
            st_d.bitc = '0;
            st_d.slot = slot_seq;
            if (st_q.slot == LAST_SLOT) begin
                st_d.frame = frame_inc;
            end
            load_d = 1'b1;
        end else begin
            st_d.bitc = st_q.bitc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_q    = st_q.slot;
    assign frame_q   = st_q.frame;
    assign load      = load_d;
    assign nxt_slot  = st_d.slot;
    assign nxt_frame = st_d.frame;
    // channel owning the slot that follows the current one
    assign req_ch    = CH_W'(slot_seq - VF_S);

endmodule

// File: rtl/e1sm_byte_sel.sv
module e1sm_byte_sel
    import e1sm_pkg::*;
#(
    parameter int unsigned   BITS          = 8,
    parameter int unsigned   SLOT_W        = 5,
    parameter int unsigned   FRM_W         = 12,
    parameter int unsigned   VOICE_FIRST   = 1,
    parameter int unsigned   VOICE_CNT     = 8,
    parameter int unsigned   SIG_SLOT      = 16,
    parameter int unsigned   SYNC_SLOT     = 17,
    parameter logic [BITS-1:0] ALIGN_WORD    = 8'h9B,
    parameter logic [BITS-1:0] NONALIGN_WORD = 8'h40,
    parameter logic [BITS-1:0] IDLE_FILL     = 8'hD5,
    parameter logic [BITS-1:0] PULSE_ON      = 8'hFF,
    parameter logic [BITS-1:0] PULSE_OFF     = 8'h00
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic [FRM_W-1:0]  frame,
    input  logic [BITS-1:0]   voice_byte,
    input  logic [BITS-1:0]   sig_byte,
    output logic [BITS-1:0]   word
);

    localparam logic [SLOT_W-1:0] VF_S   = SLOT_W'(VOICE_FIRST);
    localparam logic [SLOT_W-1:0] VL_S   = SLOT_W'(VOICE_FIRST + VOICE_CNT - 1);
    localparam logic [SLOT_W-1:0] SIG_S  = SLOT_W'(SIG_SLOT);
    localparam logic [SLOT_W-1:0] SYNC_S = SLOT_W'(SYNC_SLOT);

    slot_kind_e kind;

    always_comb begin
        if (slot == '0) begin
            kind = SK_ALIGN;
        end else if (slot >= VF_S && slot <= VL_S) begin
            kind = SK_VOICE;
        end else if (slot == SIG_S) begin
            kind = SK_SIG;
        end else if (slot == SYNC_S) begin
            kind = SK_SYNC;
        end else begin
            kind = SK_IDLE;
        end
    end

    always_comb begin
        unique case (kind)
            SK_ALIGN: word = frame[0] ? NONALIGN_WORD : ALIGN_WORD;
            SK_VOICE: word = voice_byte;
            SK_SIG:   word = sig_byte;
            SK_SYNC:  word = (frame == '0) ? PULSE_ON : PULSE_OFF;
            default:  word = IDLE_FILL;
        endcase
    end

endmodule

// File: rtl/e1sm_serializer.sv
module e1sm_serializer #(
    parameter int unsigned     BITS     = 8,
    parameter logic [BITS-1:0] RST_WORD = 8'h9B
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [BITS-1:0] din,
    output logic [BITS-1:0] sh_q,
    output logic            ser_out
);

    logic [BITS-1:0] sh_d;

    always_comb begin
        if (load) begin
            sh_d = din;
        end else begin
            sh_d = {sh_q[BITS-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= RST_WORD;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign ser_out = sh_q[BITS-1];

endmodule

// File: rtl/e1_slot_mapper.sv
module e1_slot_mapper
    import e1sm_pkg::*;
#(
    parameter int unsigned SLOTS       = DEF_SLOTS,
    parameter int unsigned BITS        = DEF_BITS,
    parameter int unsigned PERIOD      = DEF_PERIOD,
    parameter int unsigned VOICE_FIRST = DEF_VOICE_FIRST,
    parameter int unsigned VOICE_CNT   = DEF_VOICE_CNT,
    parameter int unsigned SIG_SLOT    = DEF_SIG_SLOT,
    parameter int unsigned SYNC_SLOT   = DEF_SYNC_SLOT,
    parameter logic [BITS-1:0] ALIGN_WORD    = DEF_ALIGN_WORD,
    parameter logic [BITS-1:0] NONALIGN_WORD = DEF_NONALIGN_WORD,
    parameter logic [BITS-1:0] IDLE_FILL     = DEF_IDLE_FILL,
    parameter logic [BITS-1:0] PULSE_ON      = DEF_PULSE_ON,
    parameter logic [BITS-1:0] PULSE_OFF     = DEF_PULSE_OFF,
    localparam int unsigned SLOT_W = $clog2(SLOTS),
    localparam int unsigned FRM_W  = $clog2(PERIOD),
    localparam int unsigned CH_W   = (VOICE_CNT > 1) ? $clog2(VOICE_CNT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_strobe,
    input  logic [BITS-1:0]   voice_byte,
    output logic [CH_W-1:0]   voice_ch,
    input  logic [BITS-1:0]   sig_byte,
    output logic              tx_bit,
    output logic [SLOT_W-1:0] tx_slot
);

    logic              load_w;
    logic [SLOT_W-1:0] nxt_slot_w;
    logic [FRM_W-1:0]  nxt_frame_w;
    logic [FRM_W-1:0]  frame_w;
    logic [BITS-1:0]   word_w;
    logic [BITS-1:0]   sh_w;

    e1sm_timebase #(
        .SLOTS       (SLOTS),
        .BITS        (BITS),
        .PERIOD      (PERIOD),
        .VOICE_FIRST (VOICE_FIRST),
        .SLOT_W      (SLOT_W),
        .FRM_W       (FRM_W),
        .CH_W        (CH_W)
    ) u_timebase (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_strobe (frame_strobe),
        .slot_q       (tx_slot),
        .frame_q      (frame_w),
        .load         (load_w),
        .nxt_slot     (nxt_slot_w),
        .nxt_frame    (nxt_frame_w),
        .req_ch       (voice_ch)
    );

    e1sm_byte_sel #(
        .BITS          (BITS),
        .SLOT_W        (SLOT_W),
        .FRM_W         (FRM_W),
        .VOICE_FIRST   (VOICE_FIRST),
        .VOICE_CNT     (VOICE_CNT),
        .SIG_SLOT      (SIG_SLOT),
        .SYNC_SLOT     (SYNC_SLOT),
        .ALIGN_WORD    (ALIGN_WORD),
        .NONALIGN_WORD (NONALIGN_WORD),
        .IDLE_FILL     (IDLE_FILL),
        .PULSE_ON      (PULSE_ON),
        .PULSE_OFF     (PULSE_OFF)
    ) u_byte_sel (
        .slot       (nxt_slot_w),
        .frame      (nxt_frame_w),
        .voice_byte (voice_byte),
        .sig_byte   (sig_byte),
        .word       (word_w)
    );

    e1sm_serializer #(
        .BITS     (BITS),
        .RST_WORD (ALIGN_WORD)
    ) u_serializer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_w),
        .din     (word_w),
        .sh_q    (sh_w),
        .ser_out (tx_bit)
    );

endmodule

// File: rtl/e1sm_checker.sv
module e1sm_checker #(
    parameter int unsigned SLOTS       = 32,
    parameter int unsigned BITS        = 8,
    parameter int unsigned PERIOD      = 2560,
    parameter int unsigned VOICE_FIRST = 1,
    parameter int unsigned VOICE_CNT   = 8,
    parameter int unsigned SIG_SLOT    = 16,
    parameter int unsigned SYNC_SLOT   = 17,
    parameter logic [BITS-1:0] ALIGN_WORD    = 8'h9B,
    parameter logic [BITS-1:0] NONALIGN_WORD = 8'h40,
    parameter logic [BITS-1:0] IDLE_FILL     = 8'hD5,
    parameter logic [BITS-1:0] PULSE_ON      = 8'hFF,
    parameter int unsigned SLOT_W = 5,
    parameter int unsigned FRM_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fs,
    input logic [BITS-1:0]   sig_byte,
    input logic              ld,
    input logic [SLOT_W-1:0] nxt_slot,
    input logic [FRM_W-1:0]  nxt_frame,
    input logic [SLOT_W-1:0] tx_slot,
    input logic [FRM_W-1:0]  frame_q,
    input logic [BITS-1:0]   sh_q
);

    localparam logic [SLOT_W-1:0] LAST_S = SLOT_W'(SLOTS - 1);
    localparam logic [SLOT_W-1:0] VL_S   = SLOT_W'(VOICE_FIRST + VOICE_CNT - 1);
    localparam logic [SLOT_W-1:0] SIG_S  = SLOT_W'(SIG_SLOT);
    localparam logic [SLOT_W-1:0] SYNC_S = SLOT_W'(SYNC_SLOT);
    localparam logic [FRM_W-1:0]  PER_F  = FRM_W'(PERIOD);

    logic nxt_idle;
    assign nxt_idle = (nxt_slot > VL_S) && (nxt_slot != SIG_S) && (nxt_slot != SYNC_S);

    // R1: slot index steps by one at each slot boundary
    a_r1_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !fs && tx_slot != LAST_S) |=> tx_slot == $past(tx_slot) + 1'b1);

    // R1: slot index holds between boundaries
    a_r1_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(tx_slot));

    // R7: strobe restarts at slot 0
    a_r7_realign: assert property (@(posedge clk) disable iff (!rst_n)
        fs |=> tx_slot == '0);

    // R2: alignment word by frame parity
    a_r2_align_word: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && nxt_slot == '0) |=>
            sh_q == ($past(nxt_frame[0]) ? NONALIGN_WORD : ALIGN_WORD));

    // R4: filler in unused slots
    a_r4_idle_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && nxt_idle) |=> sh_q == IDLE_FILL);

    // R5: signalling byte captured at slot start
    a_r5_sig_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && nxt_slot == SIG_S) |=> sh_q == $past(sig_byte));

    // R6: marker only in frame 0
    a_r6_pulse_word: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && nxt_slot == SYNC_S) |=> (sh_q == PULSE_ON) == ($past(nxt_frame) == '0));

    // R6: frame number stays in range
    a_r6_frame_range: assert property (@(posedge clk) disable iff (!rst_n)
        frame_q < PER_F);

endmodule

bind e1_slot_mapper e1sm_checker #(
    .SLOTS         (SLOTS),
    .BITS          (BITS),
    .PERIOD        (PERIOD),
    .VOICE_FIRST   (VOICE_FIRST),
    .VOICE_CNT     (VOICE_CNT),
    .SIG_SLOT      (SIG_SLOT),
    .SYNC_SLOT     (SYNC_SLOT),
    .ALIGN_WORD    (ALIGN_WORD),
    .NONALIGN_WORD (NONALIGN_WORD),
    .IDLE_FILL     (IDLE_FILL),
    .PULSE_ON      (PULSE_ON),
    .SLOT_W        (SLOT_W),
    .FRM_W         (FRM_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fs        (frame_strobe),
    .sig_byte  (sig_byte),
    .ld        (load_w),
    .nxt_slot  (nxt_slot_w),
    .nxt_frame (nxt_frame_w),
    .tx_slot   (tx_slot),
    .frame_q   (frame_w),
    .sh_q      (sh_w)
);

// File: tb/e1_slot_mapper_tb.sv
module e1_slot_mapper_tb;

    logic       clk;
    logic       rst_n;
    logic       frame_strobe;
    logic [7:0] voice_byte;
    logic [2:0] voice_ch;
    logic [7:0] sig_byte;
    logic       tx_bit;
    logic [4:0] tx_slot;

    logic [7:0] vmem [8];
    logic [7:0] cap  [32];
    logic [7:0] c0   [32];
    logic [7:0] c1   [32];

    int n_tests = 0;
    int n_fail  = 0;

    // {frame select, slot, expected byte}
    localparam int NVEC = 15;
    localparam logic [13:0] VEC [NVEC] = '{
        {1'b0, 5'd0,  8'h9B}, {1'b0, 5'd1,  8'h11}, {1'b0, 5'd4,  8'h44},
        {1'b0, 5'd8,  8'h88}, {1'b0, 5'd9,  8'hD5}, {1'b0, 5'd15, 8'hD5},
        {1'b0, 5'd16, 8'h5A}, {1'b0, 5'd17, 8'hFF}, {1'b0, 5'd18, 8'hD5},
        {1'b0, 5'd31, 8'hD5}, {1'b1, 5'd0,  8'h40}, {1'b1, 5'd3,  8'h33},
        {1'b1, 5'd16, 8'hA5}, {1'b1, 5'd17, 8'h00}, {1'b1, 5'd20, 8'hD5}
    };

    e1_slot_mapper u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_strobe (frame_strobe),
        .voice_byte   (voice_byte),
        .voice_ch     (voice_ch),
        .sig_byte     (sig_byte),
        .tx_bit       (tx_bit),
        .tx_slot      (tx_slot)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    assign voice_byte = vmem[voice_ch];

    function automatic string req_of(input int s);
        if (s == 0) return "R2";
        if (s >= 1 && s <= 8) return "R3";
        if (s == 16) return "R5";
        if (s == 17) return "R6";
        return "R4";
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // samples one frame, 256 bits; optionally rewrites channel 3 at bit poke_at
    task automatic capture(input int poke_at);
        int bad = 0;
        for (int i = 0; i < 256; i++) begin
            cap[i/8] = {cap[i/8][6:0], tx_bit};
            if (tx_slot != 5'(i / 8)) bad++;
            if (i == poke_at) vmem[3] = 8'hE7;
            @(posedge clk);
            @(negedge clk);
        end
        check(bad == 0, "R1", bad, 0);
    endtask

    initial begin
        #500_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n        = 1'b0;
        frame_strobe = 1'b0;
        sig_byte     = 8'h5A;
        for (int c = 0; c < 8; c++) vmem[c] = 8'(8'h11 * (c + 1));
        repeat (3) @(negedge clk);

        // R8: reset position and first bit
        check(tx_slot == 5'd0, "R8", tx_slot, 0);
        check(tx_bit == 1'b1, "R8", tx_bit, 1);
        check(voice_ch == 3'd0, "R3", voice_ch, 0);
        rst_n = 1'b1;

        // frames 0 and 1, checked against the table
        capture(-1);
        for (int s = 0; s < 32; s++) c0[s] = cap[s];
        sig_byte = 8'hA5;
        capture(-1);
        for (int s = 0; s < 32; s++) c1[s] = cap[s];
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] got;
            got = VEC[v][13] ? c1[VEC[v][12:8]] : c0[VEC[v][12:8]];
            check(got == VEC[v][7:0], req_of(int'(VEC[v][12:8])), got, VEC[v][7:0]);
        end

        // R3: change in mid-slot 4 is not seen until the next frame
        capture(35);
        check(cap[4] == 8'h44, "R3", cap[4], 8'h44);
        capture(-1);
        check(cap[4] == 8'hE7, "R3", cap[4], 8'hE7);

        // R7/R6: strobe held to advance frames 4 -> 2559
        frame_strobe = 1'b1;
        repeat (2555) @(negedge clk);
        frame_strobe = 1'b0;
        check(tx_slot == 5'd0, "R7", tx_slot, 0);
        capture(-1);
        check(cap[0] == 8'h40, "R2", cap[0], 8'h40);
        check(cap[17] == 8'h00, "R6", cap[17], 8'h00);

        // R6: natural wrap to frame 0 brings the marker
        capture(-1);
        check(cap[17] == 8'hFF, "R6", cap[17], 8'hFF);
        check(cap[0] == 8'h9B, "R2", cap[0], 8'h9B);

        // R7: strobe in mid-frame 1 (slot 5, bit 3) starts frame 2
        repeat (43) begin
            @(posedge clk);
            @(negedge clk);
        end
        check(tx_slot == 5'd5, "R1", tx_slot, 5);
        frame_strobe = 1'b1;
        @(negedge clk);
        frame_strobe = 1'b0;
        check(tx_slot == 5'd0, "R7", tx_slot, 0);
        capture(-1);
        check(cap[0] == 8'h9B, "R7", cap[0], 8'h9B);
        check(cap[17] == 8'h00, "R6", cap[17], 8'h00);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule